// File: doc/BRIEF.md
# Pedestal Threshold Calibrator

This block derives per-channel zero-suppression thresholds from the pedestal level of each detector channel. On a start request it runs a calibration burst: it raises an internal trigger, waits for the front end to deliver one averaged pedestal value for every channel, adds each value into that channel's accumulator, and repeats until the full burst of triggers has been served.

When the burst ends, each accumulator is divided by the trigger count with a right shift. A small offset captured at start is added, and the result is clipped to the sample range. All results are written into the threshold table in one cycle. The readout comparator reads that table through a combinational lookup port. The block then streams the new table over a valid/ready port, one word per channel.

Top module: `ped_thresh_cal`

## Requirements
- R1: When `busy_o` is low, a one-cycle `start_i` begins a run: `busy_o` is high on the next cycle, and every channel accumulator is cleared, so results never depend on an earlier run.
- R2: A run raises `trig_o` exactly 64 times, each time for one cycle. The next trigger comes only after 32 valid samples have been taken following the previous one.
- R3: A sample presented with `smp_valid_i` while the block is collecting is added to the accumulator of the channel given by `smp_chan_i`, whatever order the channels arrive in and with any idle cycles between samples.
- R4: The new threshold of a channel is (its 64-sample sum shifted right by 6) plus the `offset_i` value sampled with the accepted start strobe. Later changes to `offset_i` during the run have no effect.
- R5: A threshold that would exceed 1023 is saturated to 1023.
- R6: After reset every table entry reads 1023 on `thr_rd_o`. At the end of a run all 32 entries are overwritten with the new thresholds and can be read by putting a channel index on `thr_rd_chan_i`.
- R7: The export sends exactly 32 words in channel order 0 to 31. Bits [14:10] hold the channel index and bits [9:0] hold the threshold. A word offered while `exp_ready_i` is low stays valid and unchanged.
- R8: `busy_o` stays high until the cycle after the last export word is accepted. A `start_i` that arrives while `busy_o` is high is ignored, and no further trigger follows it.
- R9: After reset `busy_o`, `trig_o` and `exp_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request a calibration run |
| offset_i | input | 4 | Offset added to each mean pedestal |
| smp_valid_i | input | 1 | Sample present |
| smp_chan_i | input | 5 | Channel index of the sample |
| smp_data_i | input | 10 | Averaged pedestal sample |
| trig_o | output | 1 | Internal calibration trigger, one cycle |
| busy_o | output | 1 | Run in progress |
| exp_valid_o | output | 1 | Export word valid |
| exp_ready_i | input | 1 | Export sink ready |
| exp_word_o | output | 15 | {channel, threshold} export word |
| thr_rd_chan_i | input | 5 | Table lookup index |
| thr_rd_o | output | 10 | Threshold of the looked-up channel |

## Verification
The bound checker monitors the handshake and sequencing rules on every cycle. These are the one-cycle trigger pulse, the trigger count reached before the export begins, triggers and export occurring only while busy, a stalled export word held steady, channel indices rising from zero, and busy dropping right after the last word. The numeric results can only be shown by the bench scenarios: accumulation under permuted and gapped channel order, the shift-and-offset arithmetic, saturation at the top of the range, clearing between runs, offset capture, and start strobes ignored during a run. Each scenario is compared against a scoreboard computed from the sample patterns.

// File: rtl/pcal_pkg.sv
package pcal_pkg;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_CLEAR   = 3'd1,
      ST_TRIG    = 3'd2,
      ST_COLLECT = 3'd3,
      ST_UPDATE  = 3'd4,
      ST_EXPORT  = 3'd5
   } cal_state_t;

endpackage

// File: rtl/pcal_seq.sv
module pcal_seq
   import pcal_pkg::*;
#(
   parameter int NUM_CH   = 32,
   parameter int NUM_TRIG = 64
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start_i,
   input  logic                      smp_valid_i,
   input  logic                      exp_ready_i,
   output logic                      start_take_o,
   output logic                      trig_o,
   output logic                      acc_clr_o,
   output logic                      acc_en_o,
   output logic                      tbl_wr_o,
   output logic                      exp_valid_o,
   output logic [$clog2(NUM_CH)-1:0] exp_idx_o,
   output logic                      busy_o
);

   localparam int CH_W = $clog2(NUM_CH);
   localparam int TR_W = $clog2(NUM_TRIG);
   localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);
   localparam logic [TR_W-1:0] LAST_TR = TR_W'(NUM_TRIG - 1);

   cal_state_t      state_q;
   logic [TR_W-1:0] trig_cnt_q;
   logic [CH_W-1:0] smp_cnt_q;
   logic [CH_W-1:0] exp_idx_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         trig_cnt_q <= '0;
         smp_cnt_q  <= '0;
         exp_idx_q  <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) state_q <= ST_CLEAR;
            end
            ST_CLEAR: begin
               trig_cnt_q <= '0;
               state_q    <= ST_TRIG;
            end
            ST_TRIG: begin
               smp_cnt_q <= '0;
               state_q   <= ST_COLLECT;
            end
            ST_COLLECT: begin
               if (smp_valid_i) begin
                  if (smp_cnt_q == LAST_CH) begin
                     if (trig_cnt_q == LAST_TR) begin
                        state_q <= ST_UPDATE;
                     end else begin
                        trig_cnt_q <= trig_cnt_q + 1'b1;
                        state_q    <= ST_TRIG;
                     end
                  end else begin
                     smp_cnt_q <= smp_cnt_q + 1'b1;
                  end
               end
            end
            ST_UPDATE: begin
               exp_idx_q <= '0;
               state_q   <= ST_EXPORT;
            end
            ST_EXPORT: begin
               if (exp_ready_i) begin
                  if (exp_idx_q == LAST_CH) state_q <= ST_IDLE;
                  else exp_idx_q <= exp_idx_q + 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      start_take_o = (state_q == ST_IDLE) && start_i;
      trig_o       = (state_q == ST_TRIG);
      acc_clr_o    = (state_q == ST_CLEAR);
      acc_en_o     = (state_q == ST_COLLECT) && smp_valid_i;
      tbl_wr_o     = (state_q == ST_UPDATE);
      exp_valid_o  = (state_q == ST_EXPORT);
      exp_idx_o    = exp_idx_q;
      busy_o       = (state_q != ST_IDLE);
   end

endmodule

// File: rtl/pcal_acc_bank.sv
module pcal_acc_bank #(
   parameter int NUM_CH   = 32,
   parameter int SAMPLE_W = 10,
   parameter int ACC_W    = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      clr_i,
   input  logic                      en_i,
   input  logic [$clog2(NUM_CH)-1:0] chan_i,
   input  logic [SAMPLE_W-1:0]       data_i,
   output logic [ACC_W-1:0]          acc_o [NUM_CH]
);

   localparam int CH_W = $clog2(NUM_CH);

   for (genvar g = 0; g < NUM_CH; g++) begin : g_acc
      logic [ACC_W-1:0] acc_q;
      logic             hit;

      assign hit = en_i && (chan_i == CH_W'(g));

      always_ff @(posedge clk) begin
         if (!rst_n || clr_i) acc_q <= '0;
         else if (hit)        acc_q <= acc_q + ACC_W'(data_i);
      end

      assign acc_o[g] = acc_q;
   end

endmodule

// File: rtl/pcal_thr_table.sv
module pcal_thr_table #(
   parameter int NUM_CH    = 32,
   parameter int SAMPLE_W  = 10,
   parameter int ACC_W     = 16,
   parameter int OFF_W     = 4,
   parameter int SHIFT     = 6,
   parameter bit SATURATE  = 1'b1,
   parameter int RESET_THR = 1023
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_i,
   input  logic [OFF_W-1:0]          offset_i,
   input  logic [ACC_W-1:0]          acc_i [NUM_CH],
   input  logic [$clog2(NUM_CH)-1:0] rd_a_idx_i,
   output logic [SAMPLE_W-1:0]       rd_a_o,
   input  logic [$clog2(NUM_CH)-1:0] rd_b_idx_i,
   output logic [SAMPLE_W-1:0]       rd_b_o
);

   localparam int SUM_W = ACC_W - SHIFT + 1;
   localparam logic [SUM_W-1:0]    MAX_V   = SUM_W'((1 << SAMPLE_W) - 1);
   localparam logic [SAMPLE_W-1:0] INIT_V  = SAMPLE_W'(RESET_THR);

   logic [SAMPLE_W-1:0] tbl_q [NUM_CH];

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ent
      logic [SUM_W-1:0]    sum;
      logic [SAMPLE_W-1:0] nxt;

      assign sum = SUM_W'(acc_i[g] >> SHIFT) + SUM_W'(offset_i);

      if (SATURATE) begin : g_sat
         assign nxt = (sum > MAX_V) ? MAX_V[SAMPLE_W-1:0] : sum[SAMPLE_W-1:0];
      end else begin : g_wrap
         assign nxt = sum[SAMPLE_W-1:0];
      end

      always_ff @(posedge clk) begin
         if (!rst_n)    tbl_q[g] <= INIT_V;
         else if (wr_i) tbl_q[g] <= nxt;
      end
   end

   assign rd_a_o = tbl_q[rd_a_idx_i];
   assign rd_b_o = tbl_q[rd_b_idx_i];

endmodule

// File: rtl/ped_thresh_cal.sv
module ped_thresh_cal #(
   parameter int SAMPLE_W  = 10,
   parameter int NUM_CH    = 32,
   parameter int NUM_TRIG  = 64,
   parameter int OFF_W     = 4,
   parameter int ACC_W     = SAMPLE_W + $clog2(NUM_TRIG),
   parameter bit SATURATE  = 1'b1,
   parameter int RESET_THR = (1 << SAMPLE_W) - 1
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               start_i,
   input  logic [OFF_W-1:0]                   offset_i,
   input  logic                               smp_valid_i,
   input  logic [$clog2(NUM_CH)-1:0]          smp_chan_i,
   input  logic [SAMPLE_W-1:0]                smp_data_i,
   output logic                               trig_o,
   output logic                               busy_o,
   output logic                               exp_valid_o,
   input  logic                               exp_ready_i,
   output logic [$clog2(NUM_CH)+SAMPLE_W-1:0] exp_word_o,
   input  logic [$clog2(NUM_CH)-1:0]          thr_rd_chan_i,
   output logic [SAMPLE_W-1:0]                thr_rd_o
);

   localparam int CH_W  = $clog2(NUM_CH);
   localparam int SHIFT = $clog2(NUM_TRIG);

   if (NUM_CH < 2 || (1 << CH_W) != NUM_CH) begin : g_bad_ch
      $error("NUM_CH must be a power of two of at least 2");
   end
   if (NUM_TRIG < 2 || (1 << SHIFT) != NUM_TRIG) begin : g_bad_trig
      $error("NUM_TRIG must be a power of two of at least 2");
   end
   if (ACC_W < SAMPLE_W + SHIFT) begin : g_bad_acc
      $error("ACC_W too narrow for the trigger burst");
   end
   if (OFF_W > SAMPLE_W) begin : g_bad_off
      $error("OFF_W must not exceed SAMPLE_W");
   end

   logic             start_take;
   logic             acc_clr;
   logic             acc_en;
   logic             tbl_wr;
   logic [CH_W-1:0]  exp_idx;
   logic [OFF_W-1:0] off_q;
   logic [ACC_W-1:0] acc [NUM_CH];
   logic [SAMPLE_W-1:0] exp_thr;

   always_ff @(posedge clk) begin
      if (!rst_n)          off_q <= '0;
      else if (start_take) off_q <= offset_i;
   end

   pcal_seq #(
      .NUM_CH   (NUM_CH),
      .NUM_TRIG (NUM_TRIG)
   ) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .smp_valid_i  (smp_valid_i),
      .exp_ready_i  (exp_ready_i),
      .start_take_o (start_take),
      .trig_o       (trig_o),
      .acc_clr_o    (acc_clr),
      .acc_en_o     (acc_en),
      .tbl_wr_o     (tbl_wr),
      .exp_valid_o  (exp_valid_o),
      .exp_idx_o    (exp_idx),
      .busy_o       (busy_o)
   );

   pcal_acc_bank #(
      .NUM_CH   (NUM_CH),
      .SAMPLE_W (SAMPLE_W),
      .ACC_W    (ACC_W)
   ) u_acc (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (acc_clr),
      .en_i   (acc_en),
      .chan_i (smp_chan_i),
      .data_i (smp_data_i),
      .acc_o  (acc)
   );

   pcal_thr_table #(
      .NUM_CH    (NUM_CH),
      .SAMPLE_W  (SAMPLE_W),
      .ACC_W     (ACC_W),
      .OFF_W     (OFF_W),
      .SHIFT     (SHIFT),
      .SATURATE  (SATURATE),
      .RESET_THR (RESET_THR)
   ) u_tbl (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_i       (tbl_wr),
      .offset_i   (off_q),
      .acc_i      (acc),
      .rd_a_idx_i (exp_idx),
      .rd_a_o     (exp_thr),
      .rd_b_idx_i (thr_rd_chan_i),
      .rd_b_o     (thr_rd_o)
   );

   assign exp_word_o = {exp_idx, exp_thr};

endmodule

// File: rtl/pcal_checker.sv
module pcal_checker #(
   parameter int SAMPLE_W = 10,
   parameter int NUM_CH   = 32,
   parameter int NUM_TRIG = 64
) (
   input logic                               clk,
   input logic                               rst_n,
   input logic                               start_i,
   input logic                               trig_o,
   input logic                               busy_o,
   input logic                               exp_valid_o,
   input logic                               exp_ready_i,
   input logic [$clog2(NUM_CH)+SAMPLE_W-1:0] exp_word_o
);

   localparam int CH_W = $clog2(NUM_CH);
   localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

   logic [CH_W-1:0] chan;
   logic [31:0]     trig_seen_q;
   logic            last_xfer;

   assign chan      = exp_word_o[CH_W+SAMPLE_W-1:SAMPLE_W];
   assign last_xfer = exp_valid_o && exp_ready_i && (chan == LAST_CH);

   always_ff @(posedge clk) begin
      if (!rst_n)                  trig_seen_q <= '0;
      else if (!busy_o && start_i) trig_seen_q <= '0;
      else if (trig_o)             trig_seen_q <= trig_seen_q + 1;
   end

   AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && start_i) |=> busy_o); // R1
   AST_TRIG_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      trig_o |=> !trig_o); // R2
   AST_TRIG_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      trig_o |-> (busy_o && trig_seen_q < NUM_TRIG)); // R2
   AST_TRIG_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(exp_valid_o) |-> (trig_seen_q == NUM_TRIG)); // R2
   AST_EXP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(exp_valid_o) |-> (chan == '0)); // R7
   AST_EXP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (exp_valid_o && !exp_ready_i) |=> (exp_valid_o && $stable(exp_word_o))); // R7
   AST_EXP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (exp_valid_o && exp_ready_i && chan != LAST_CH)
         |=> (exp_valid_o && chan == $past(chan) + 1'b1)); // R7
   AST_EXP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      exp_valid_o |-> busy_o); // R8
   AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
      last_xfer |=> !busy_o); // R8

endmodule

bind ped_thresh_cal pcal_checker #(
   .SAMPLE_W (SAMPLE_W),
   .NUM_CH   (NUM_CH),
   .NUM_TRIG (NUM_TRIG)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .trig_o      (trig_o),
   .busy_o      (busy_o),
   .exp_valid_o (exp_valid_o),
   .exp_ready_i (exp_ready_i),
   .exp_word_o  (exp_word_o)
);

// File: tb/ped_thresh_cal_test.sv
module ped_thresh_cal_test;

   localparam int CYC = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [3:0]  offset_i = '0;
   logic        smp_valid_i = 1'b0;
   logic [4:0]  smp_chan_i = '0;
   logic [9:0]  smp_data_i = '0;
   logic        trig_o;
   logic        busy_o;
   logic        exp_valid_o;
   logic        exp_ready_i = 1'b1;
   logic [14:0] exp_word_o;
   logic [4:0]  thr_rd_chan_i = '0;
   logic [9:0]  thr_rd_o;

   ped_thresh_cal uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .start_i       (start_i),
      .offset_i      (offset_i),
      .smp_valid_i   (smp_valid_i),
      .smp_chan_i    (smp_chan_i),
      .smp_data_i    (smp_data_i),
      .trig_o        (trig_o),
      .busy_o        (busy_o),
      .exp_valid_o   (exp_valid_o),
      .exp_ready_i   (exp_ready_i),
      .exp_word_o    (exp_word_o),
      .thr_rd_chan_i (thr_rd_chan_i),
      .thr_rd_o      (thr_rd_o)
   );

   always #(CYC / 2) clk = ~clk;

   int n_checks = 0;
   int n_fails  = 0;
   int trig_seen = 0;
   int exp_q[$];
   int exp_thr[32];
   bit stall_en = 1'b0;
   logic [7:0] lfsr = 8'hA5;
   bit done = 1'b0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int smp_val(input int run, input int t, input int ch);
      case (run)
         0:       return (ch * 37 + t * 13 + (t * ch) % 11) % 1024;
         1:       return 1023 - ch;
         default: return 0;
      endcase
   endfunction

   function automatic int ch_order(input int run, input int k);
      case (run)
         0:       return (k * 7) % 32;
         1:       return k;
         default: return 31 - k;
      endcase
   endfunction

   // ready generator
   always @(negedge clk) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      exp_ready_i = stall_en ? (lfsr[0] | lfsr[2]) : 1'b1;
   end

   // monitor / scoreboard
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (trig_o) trig_seen++;
         if (exp_valid_o && exp_ready_i) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R7 unexpected export word", int'(exp_word_o), -1);
            end else begin
               int e;
               e = exp_q.pop_front();
               chk(int'(exp_word_o) == e, "R4/R5/R7 export word", int'(exp_word_o), e);
            end
         end
      end
   end

   task automatic run_cal(input int run, input int off, input bit gaps, input bit poke_start);
      int t0;
      for (int ch = 0; ch < 32; ch++) begin
         int s;
         int th;
         s = 0;
         for (int t = 0; t < 64; t++) s += smp_val(run, t, ch);
         th = s / 64 + off;
         if (th > 1023) th = 1023;
         exp_thr[ch] = th;
         exp_q.push_back((ch << 10) | th);
      end
      t0 = trig_seen;
      @(negedge clk);
      start_i  = 1'b1;
      offset_i = 4'(off);
      @(negedge clk);
      start_i  = 1'b0;
      offset_i = 4'(off) ^ 4'hF;   // must not affect the run (R4)
      #1;
      chk(busy_o == 1'b1, "R1 busy after start", int'(busy_o), 1);
      for (int t = 0; t < 64; t++) begin
         while (!trig_o) @(negedge clk);
         for (int k = 0; k < 32; k++) begin
            @(negedge clk);
            if (gaps && (k % 5 == 0)) begin
               smp_valid_i = 1'b0;
               @(negedge clk);
            end
            smp_valid_i = 1'b1;
            smp_chan_i  = 5'(ch_order(run, k));
            smp_data_i  = 10'(smp_val(run, t, ch_order(run, k)));
         end
         @(negedge clk);
         smp_valid_i = 1'b0;
      end
      if (poke_start) begin
         while (!exp_valid_o) @(negedge clk);
         start_i = 1'b1;   // ignored while busy (R8)
         @(negedge clk);
         start_i = 1'b0;
      end
      while (busy_o) @(negedge clk);
      #1;
      chk(exp_q.size() == 0, "R7 all 32 words exported", exp_q.size(), 0);
      chk(trig_seen - t0 == 64, "R2 trigger count", trig_seen - t0, 64);
      if (poke_start) begin
         repeat (20) @(negedge clk);
         #1;
         chk(busy_o == 1'b0, "R8 start while busy ignored (busy)", int'(busy_o), 0);
         chk(trig_seen - t0 == 64, "R8 start while busy ignored (trig)", trig_seen - t0, 64);
      end
      for (int ch = 0; ch < 32; ch++) begin
         @(negedge clk);
         thr_rd_chan_i = 5'(ch);
         #1;
         chk(int'(thr_rd_o) == exp_thr[ch], "R6 table readback", int'(thr_rd_o), exp_thr[ch]);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      chk(busy_o == 1'b0, "R9 busy after reset", int'(busy_o), 0);
      chk(trig_o == 1'b0, "R9 trig after reset", int'(trig_o), 0);
      chk(exp_valid_o == 1'b0, "R9 export idle after reset", int'(exp_valid_o), 0);
      thr_rd_chan_i = 5'd0;
      #1;
      chk(int'(thr_rd_o) == 1023, "R6 reset table entry 0", int'(thr_rd_o), 1023);
      thr_rd_chan_i = 5'd31;
      #1;
      chk(int'(thr_rd_o) == 1023, "R6 reset table entry 31", int'(thr_rd_o), 1023);

      // R3 R4 R7: permuted order, stalled export, start poked while busy
      stall_en = 1'b1;
      run_cal(0, 5, 1'b0, 1'b1);
      // R5: saturation boundary at channel 15
      stall_en = 1'b0;
      run_cal(1, 15, 1'b0, 1'b0);
      // R1 R3: all-zero pedestals after nonzero runs, reversed with gaps
      stall_en = 1'b1;
      run_cal(2, 0, 1'b1, 1'b0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

   initial begin
      #(CYC * 150000);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end

endmodule